// File: doc/BRIEF.md
# Indirect Register Access Port

This block lets a host reach a bank of 32-bit internal registers through six narrow 16-bit direct registers. The host stages data, then writes an index address. That address write is the only thing that starts an internal transfer. Bit 7 of the address chooses a read (set) or a write (clear). The bits above bit 0 choose the internal register. For reads, bit 0 chooses which halfword comes back.

A transfer takes a fixed number of clocks. During that time a busy flag in the status register is set, and software polls it before it goes on. Because each read returns only 16 bits, a full 32-bit value is read as two transactions. A single-bit update is a read transaction followed by a write transaction of the modified value.

The status register also holds two active-low reset controls. One is a global reset, which clears the internal bank and stops transfers. The other is a codec reset, which is simply driven out of the block.

Top module: `ixp_port`

## Requirements
- R1: After `rst_ni` is deasserted, both reset outputs are low (asserted) and the status register reads 0.
- R2: The status register is select 0: bit 0 is busy (read-only), bit 1 is the global reset control and bit 2 is the codec reset control, both active-low. Writing 0 drives both outputs low, and writing 6 releases both.
- R3: An address write with bit 7 clear stores {data1, data0} into the internal register numbered by address bits [4:1] (for 16 registers) when the transaction completes.
- R4: An address write with bit 7 set loads data0 with the target's low halfword if address bit 0 is 0, or with its high halfword if address bit 0 is 1. Data1, data2 and data3 are left unchanged.
- R5: The busy bit rises in the cycle after an accepted address write, stays set for exactly LAT cycles (default 4) and then clears.
- R6: While busy, writes to the address register and to the data registers are ignored. The stored address and data keep their earlier values.
- R7: While the global reset control is 0, every internal register reads as zero and address writes start nothing. A transfer in progress is abandoned, and busy is clear by the second clock.
- R8: Asserting only the codec reset drives `codec_rst_no` low and leaves the internal registers intact.
- R9: A read of a register followed by a write of a modified value updates only the intended bits.
- R10: The direct map is: select 1 is the address, selects 2 to 5 are data0 to data3, all readable back. Selects 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| bus_wr_i | input | 1 | Host write strobe for the selected direct register |
| bus_sel_i | input | 3 | Direct register select |
| bus_wdata_i | input | 16 | Host write data |
| bus_rdata_o | output | 16 | Read data of the selected direct register (combinational) |
| glob_rst_no | output | 1 | Global reset control, active low |
| codec_rst_no | output | 1 | Codec reset control, active low |

## Verification
The checks that run on every cycle cover the following:
- busy only starts after an accepted address write;
- busy lasts no more than LAT cycles, and exactly LAT when no abort occurs;
- the upper data registers hold steady while busy;
- a zero status write asserts both resets;
- global reset clears the bank and drops busy.

Data movement needs the bench's scenarios:
- which halfword lands in data0, and full 32-bit write-back through a sweep of every register;
- rejection of address and data writes while busy, the read-modify-write sequence, and codec-only reset keeping contents.

// File: rtl/ixp_pkg.sv
package ixp_pkg;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned RD_FLAG_BIT = 7;

    typedef enum logic [2:0] {
        SEL_STAT = 3'd0,
        SEL_ADDR = 3'd1,
        SEL_D0   = 3'd2,
        SEL_D1   = 3'd3,
        SEL_D2   = 3'd4,
        SEL_D3   = 3'd5
    } sel_e;

    typedef struct packed {
        logic                        glob_n;
        logic                        codec_n;
        logic [HALF_W-1:0]           addr;
        logic [3:0][HALF_W-1:0]      data;
    } port_st_t;
endpackage

// File: rtl/ixp_seq.sv
module ixp_seq #(
    parameter int unsigned LAT = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic launch_i,
    input  logic abort_i,
    output logic busy_o,
    output logic done_o
);
    localparam int unsigned CW = $clog2(LAT + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } seq_st_t;

    seq_st_t seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        done_o = 1'b0;
        if (abort_i) begin
            seq_d.busy = 1'b0;
            seq_d.cnt  = '0;
        end else if (seq_q.busy) begin
            if (seq_q.cnt == '0) begin
                seq_d.busy = 1'b0;
                done_o     = 1'b1;
            end else begin
                seq_d.cnt = seq_q.cnt - CW'(1);
            end
        end else if (launch_i) begin
            seq_d.busy = 1'b1;
            seq_d.cnt  = CW'(LAT - 1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '0;
        else         seq_q <= seq_d;
    end

    assign busy_o = seq_q.busy;
endmodule

// File: rtl/ixp_regfile.sv
module ixp_regfile #(
    parameter int unsigned NREG = 16,
    parameter int unsigned DW   = 32
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    clear_i,
    input  logic                    we_i,
    input  logic [$clog2(NREG)-1:0] idx_i,
    input  logic [DW-1:0]           wdata_i,
    output logic [DW-1:0]           rdata_o
);
    logic [NREG-1:0][DW-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (clear_i) begin
            mem_d = '0;
        end else if (we_i) begin
            mem_d[idx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mem_q <= '0;
        else         mem_q <= mem_d;
    end

    assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/ixp_port.sv
module ixp_port #(
    parameter int unsigned NREG = 16,
    parameter int unsigned LAT  = 4
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        bus_wr_i,
    input  logic [2:0]  bus_sel_i,
    input  logic [15:0] bus_wdata_i,
    output logic [15:0] bus_rdata_o,
    output logic        glob_rst_no,
    output logic        codec_rst_no
);
    import ixp_pkg::*;

    localparam int unsigned IW = $clog2(NREG);
    localparam int unsigned DW = 2 * HALF_W;

    port_st_t        st_d, st_q;
    logic            busy, done, launch, abort;
    logic [IW-1:0]   rf_idx;
    logic [DW-1:0]   rf_rdata;
    logic            rf_we;

    assign launch = bus_wr_i && (bus_sel_i == SEL_ADDR) && !busy && st_q.glob_n;
    assign abort  = !st_q.glob_n;
    assign rf_idx = st_q.addr[IW:1];
    assign rf_we  = done && !st_q.addr[RD_FLAG_BIT];

    ixp_seq #(.LAT(LAT)) u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .launch_i (launch),
        .abort_i  (abort),
        .busy_o   (busy),
        .done_o   (done)
    );

    ixp_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (abort),
        .we_i    (rf_we),
        .idx_i   (rf_idx),
        .wdata_i ({st_q.data[1], st_q.data[0]}),
        .rdata_o (rf_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (bus_wr_i) begin
            case (bus_sel_i)
                SEL_STAT: begin
                    st_d.glob_n  = bus_wdata_i[1];
                    st_d.codec_n = bus_wdata_i[2];
                end
                SEL_ADDR: if (launch) st_d.addr = bus_wdata_i;
                SEL_D0:   if (!busy) st_d.data[0] = bus_wdata_i;
                SEL_D1:   if (!busy) st_d.data[1] = bus_wdata_i;
                SEL_D2:   if (!busy) st_d.data[2] = bus_wdata_i;
                SEL_D3:   if (!busy) st_d.data[3] = bus_wdata_i;
                default:  ;
            endcase
        end
        if (done && st_q.addr[RD_FLAG_BIT]) begin
            st_d.data[0] = st_q.addr[0] ? rf_rdata[DW-1:HALF_W] : rf_rdata[HALF_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        case (bus_sel_i)
            SEL_STAT: bus_rdata_o = {13'd0, st_q.codec_n, st_q.glob_n, busy};
            SEL_ADDR: bus_rdata_o = st_q.addr;
            SEL_D0:   bus_rdata_o = st_q.data[0];
            SEL_D1:   bus_rdata_o = st_q.data[1];
            SEL_D2:   bus_rdata_o = st_q.data[2];
            SEL_D3:   bus_rdata_o = st_q.data[3];
            default:  bus_rdata_o = '0;
        endcase
    end

    assign glob_rst_no  = st_q.glob_n;
    assign codec_rst_no = st_q.codec_n;
endmodule

// File: rtl/ixp_port_chk.sv
module ixp_port_chk #(
    parameter int unsigned LAT = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_wr_i,
    input logic [2:0]        bus_sel_i,
    input logic [15:0]       bus_wdata_i,
    input logic              busy,
    input ixp_pkg::port_st_t st_q,
    input logic              glob_rst_no,
    input logic              codec_rst_no,
    input logic [31:0]       rf_rdata
);
    logic [15:0] bcnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   bcnt_q <= '0;
        else if (busy) bcnt_q <= bcnt_q + 16'd1;
        else           bcnt_q <= '0;
    end

    assert_start_on_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy) |-> $past(bus_wr_i && bus_sel_i == 3'd1 && glob_rst_no));

    assert_busy_max_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy |-> bcnt_q < 16'(LAT));

    assert_busy_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(busy) && $past(glob_rst_no)) |-> bcnt_q == 16'(LAT));

    assert_data_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy |=> ($stable(st_q.data[1]) && $stable(st_q.data[2]) && $stable(st_q.data[3])));

    assert_stat_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_sel_i == 3'd0 && bus_wdata_i[2:1] == 2'b00) |=> (!glob_rst_no && !codec_rst_no));

    assert_bank_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !glob_rst_no |=> rf_rdata == 32'd0);

    assert_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !glob_rst_no |=> !busy);
endmodule

bind ixp_port ixp_port_chk #(.LAT(LAT)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_wr_i     (bus_wr_i),
    .bus_sel_i    (bus_sel_i),
    .bus_wdata_i  (bus_wdata_i),
    .busy         (busy),
    .st_q         (st_q),
    .glob_rst_no  (glob_rst_no),
    .codec_rst_no (codec_rst_no),
    .rf_rdata     (rf_rdata)
);

// File: tb/tb_ixp_port.sv
module tb_ixp_port;
    localparam int NREG = 16;
    localparam int LAT  = 4;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  sel = 3'd0;
    logic [15:0] wd = 16'd0;
    logic [15:0] rdata;
    logic        grst_n, crst_n;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ixp_port #(.NREG(NREG), .LAT(LAT)) dut (
        .clk_i        (clk),
        .rst_ni       (rst_ni),
        .bus_wr_i     (wr),
        .bus_sel_i    (sel),
        .bus_wdata_i  (wd),
        .bus_rdata_o  (rdata),
        .glob_rst_no  (grst_n),
        .codec_rst_no (crst_n)
    );

    function automatic logic [31:0] pat(int i);
        return (32'(i + 1) * 32'h1357_9BDF) ^ 32'hC0DE_0000;
    endfunction
    function automatic logic [15:0] a_wr(int i);
        return 16'(i * 2);
    endfunction
    function automatic logic [15:0] a_rd(int i, int hi);
        return 16'h0080 | 16'(i * 2) | 16'(hi);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [2:0] s, input logic [15:0] v);
        @(negedge clk);
        wr = 1'b1; sel = s; wd = v;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic brd(input logic [2:0] s, output logic [15:0] v);
        sel = s;
        #1;
        v = rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] st;
        for (int k = 0; k < 64; k++) begin
            brd(3'd0, st);
            if (!st[0]) break;
            @(negedge clk);
        end
    endtask

    task automatic iwrite(input int i, input logic [31:0] v);
        bwr(3'd2, v[15:0]);
        bwr(3'd3, v[31:16]);
        bwr(3'd4, 16'd0);
        bwr(3'd5, 16'd0);
        bwr(3'd1, a_wr(i));
        wait_idle();
    endtask

    task automatic iread(input int i, output logic [31:0] v);
        logic [15:0] lo, hi;
        bwr(3'd1, a_rd(i, 0));
        wait_idle();
        brd(3'd2, lo);
        bwr(3'd1, a_rd(i, 1));
        wait_idle();
        brd(3'd2, hi);
        v = {hi, lo};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v16;
        logic [31:0] v32, v2;
        int cnt;

        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);

        // R1 reset state
        brd(3'd0, v16);
        check("R1 status", 32'(v16), 32'd0);
        check("R1 glob", 32'(grst_n), 32'd0);
        check("R1 codec", 32'(crst_n), 32'd0);

        // R7 address write ignored while global reset asserted
        bwr(3'd1, a_rd(2, 0));
        brd(3'd0, v16);
        check("R7 no launch in reset", 32'(v16[0]), 32'd0);
        brd(3'd1, v16);
        check("R7 addr unchanged in reset", 32'(v16), 32'd0);

        // R2 release
        bwr(3'd0, 16'd6);
        brd(3'd0, v16);
        check("R2 status released", 32'(v16), 32'd6);
        check("R2 glob out", 32'(grst_n), 32'd1);
        check("R2 codec out", 32'(crst_n), 32'd1);

        // R3 / R4 sweep over the whole bank
        for (int i = 0; i < NREG; i++) iwrite(i, pat(i));
        for (int i = 0; i < NREG; i++) begin
            iread(i, v32);
            check($sformatf("R3 R4 reg %0d", i), v32, pat(i));
        end
        brd(3'd3, v16);
        check("R4 data1 untouched by read", 32'(v16), 32'(pat(NREG - 1) >> 16));

        // R5 busy length
        bwr(3'd1, a_rd(2, 0));
        cnt = 0;
        for (int k = 0; k < 64; k++) begin
            brd(3'd0, v16);
            if (!v16[0]) break;
            cnt++;
            @(negedge clk);
        end
        check("R5 busy cycles", 32'(cnt), 32'(LAT));

        // R6 writes while busy ignored
        bwr(3'd2, 16'h1111);
        bwr(3'd3, 16'h2222);
        bwr(3'd1, a_wr(5));
        bwr(3'd2, 16'hBEEF);
        bwr(3'd1, a_rd(7, 0));
        wait_idle();
        brd(3'd1, v16);
        check("R6 addr kept", 32'(v16), 32'(a_wr(5)));
        brd(3'd2, v16);
        check("R6 data0 kept", 32'(v16), 32'h1111);
        iread(5, v32);
        check("R6 reg written with staged", v32, 32'h2222_1111);

        // R8 codec reset only
        bwr(3'd0, 16'd2);
        check("R8 codec low", 32'(crst_n), 32'd0);
        check("R8 glob high", 32'(grst_n), 32'd1);
        iread(0, v32);
        check("R8 bank intact", v32, pat(0));
        bwr(3'd0, 16'd6);

        // R9 read-modify-write
        iread(9, v32);
        v2 = v32 | 32'h0001_0040;
        iwrite(9, v2);
        iread(9, v32);
        check("R9 rmw result", v32, pat(9) | 32'h0001_0040);
        iread(8, v32);
        check("R9 neighbour untouched", v32, pat(8));

        // R10 direct map
        bwr(3'd4, 16'h5A5A);
        bwr(3'd5, 16'hA5A5);
        brd(3'd4, v16);
        check("R10 data2", 32'(v16), 32'h5A5A);
        brd(3'd5, v16);
        check("R10 data3", 32'(v16), 32'hA5A5);
        brd(3'd6, v16);
        check("R10 sel6", 32'(v16), 32'd0);
        brd(3'd7, v16);
        check("R10 sel7", 32'(v16), 32'd0);

        // R7 abort in flight, then bank cleared
        bwr(3'd2, 16'h7777);
        bwr(3'd1, a_wr(3));
        bwr(3'd0, 16'd0);
        @(negedge clk);
        brd(3'd0, v16);
        check("R7 busy dropped", 32'(v16[0]), 32'd0);
        check("R7 glob low", 32'(grst_n), 32'd0);
        bwr(3'd0, 16'd6);
        for (int i = 0; i < NREG; i++) begin
            iread(i, v32);
            check($sformatf("R7 cleared reg %0d", i), v32, 32'd0);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule